// File: doc/BRIEF.md
# Text-Mode Raster Display Controller

This block drives a VGA-style monitor from a single pixel clock. It keeps a column counter and a row counter that walk the full raster, including blanking, and turns them into active-low horizontal and vertical sync pulses. Inside the visible area it paints a grid of character cells. Each cell's character code is held in a preloaded code buffer. The glyph for each code comes from a computed font.

Each 8x8 glyph is enlarged by an integer factor, so one font pixel fills a square of screen pixels. Each screen pixel shows either the foreground or the background colour, and both colours are 3-bit inputs. The lookup runs through two register stages: first the code buffer read, then the font read with the colour select. The sync outputs are delayed by the same two cycles, so every pixel lands at its own raster position. The colour lines are held at zero at every position outside the visible area.

Top module: `txtvga_top`

## Requirements
- R1: While `rst_n` is low, and for the first two clock cycles after it rises, the outputs are idle: `hsync_n`=1, `vsync_n`=1 and red, green and blue are all 0.
- R2: A line lasts H_ACT+H_FP+H_SYNC+H_BP pixel clocks (default 640+16+96+48=800). `hsync_n` is low exactly for columns H_ACT+H_FP up to H_ACT+H_FP+H_SYNC-1.
- R3: A frame lasts V_ACT+V_FP+V_SYNC+V_BP lines (default 480+10+2+33=525). `vsync_n` is low exactly for rows V_ACT+V_FP up to V_ACT+V_FP+V_SYNC-1, and it changes only at column 0.
- R4: Red, green and blue are 0 whenever the column is at least H_ACT or the row is at least V_ACT.
- R5: The screen is a grid of cells of 8*SCALE by 8*SCALE pixels, with COLS=H_ACT/(8*SCALE) cells per row. The cell at cell-row r and cell-column c holds the 7-bit code 32 + ((r*COLS + c) mod 95), loaded at elaboration.
- R6: Glyph line y (0..7) of code c is the byte 0 when y=0, and otherwise (2*c XOR y) mod 256. Bit 7 of that byte is the leftmost font pixel.
- R7: Each font pixel covers SCALE columns by SCALE rows of the screen (default SCALE=2, giving 16x16 cells and a 40x30 grid). The glyph line is (row mod 8*SCALE)/SCALE and the glyph column is (column mod 8*SCALE)/SCALE.
- R8: An active pixel whose glyph bit is 1 shows `fg_rgb`, and one whose bit is 0 shows `bg_rgb`. The colour is taken from the value present at the clock edge that registers the pixel. Bit 2 drives red, bit 1 drives green and bit 0 drives blue.
- R9: The raster position held by the counters in cycle n shows up on all outputs, syncs and colour together, in cycle n+2. The counters start at column 0, row 0 in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fg_rgb | input | 3 | Foreground colour {R,G,B} |
| bg_rgb | input | 3 | Background colour {R,G,B} |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red on/off |
| green | output | 1 | Green on/off |
| blue | output | 1 | Blue on/off |

## Verification
The first frames run with white on black. A white-on-black frame exposes any error in glyph bits, cell addressing or scaling, because every wrong bit flips a pixel between 7 and 0. The next frame uses two complementary colours, which separates a swapped foreground and background from a wrong glyph bit. A colour change in the middle of an active line tests the registering edge of the colour select. A reset in the middle of a frame shows whether the counters and both pipeline stages restart together, so that syncs and pixels stay aligned after the second release.

// File: rtl/txtvga_pkg.sv
package txtvga_pkg;

    localparam int GLYPH_PX = 8;

    typedef logic [2:0] rgb_t;

    // Computed font: line 0 is blank, the other lines mix the code with the line number.
    function automatic logic [7:0] glyph_line(input logic [6:0] code, input logic [2:0] line);
        if (line == 3'd0) begin
            return 8'h00;
        end
        return {code, 1'b0} ^ {5'd0, line};
    endfunction

endpackage

// File: rtl/txtvga_timing.sv
module txtvga_timing #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk_pix,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          active,
    output logic          in_hsync,
    output logic          in_vsync
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.h == HW'(H_TOT - 1)) begin
            cnt_d.h = '0;
            cnt_d.v = (cnt_q.v == VW'(V_TOT - 1)) ? '0 : cnt_q.v + 1'b1;
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hpos     = cnt_q.h;
    assign vpos     = cnt_q.v;
    assign active   = (cnt_q.h < HW'(H_ACT)) && (cnt_q.v < VW'(V_ACT));
    assign in_hsync = (cnt_q.h >= HW'(H_ACT + H_FP)) && (cnt_q.h < HW'(H_ACT + H_FP + H_SYNC));
    assign in_vsync = (cnt_q.v >= VW'(V_ACT + V_FP)) && (cnt_q.v < VW'(V_ACT + V_FP + V_SYNC));

endmodule

// File: rtl/txtvga_charbuf.sv
module txtvga_charbuf #(
    parameter int NCELLS = 1200,
    parameter int IW     = 11
) (
    input  logic          clk_pix,
    input  logic          rst_n,
    input  logic [IW-1:0] cell_idx,
    output logic [6:0]    code
);
    logic [6:0] mem [NCELLS];
    logic [6:0] code_d, code_q;

    // Preloaded screen: printable codes cycling through the grid.
    initial begin
        for (int i = 0; i < NCELLS; i++) begin
            mem[i] = 7'(32 + (i % 95));
        end
    end

    always_comb begin
        code_d = mem[cell_idx];
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

endmodule

// File: rtl/txtvga_font.sv
module txtvga_font
    import txtvga_pkg::*;
(
    input  logic [6:0] code,
    input  logic [2:0] line,
    input  logic [2:0] col,
    output logic       pix
);
    logic [7:0] bits;

    always_comb begin
        bits = glyph_line(code, line);
        pix  = bits[3'd7 - col];
    end

endmodule

// File: rtl/txtvga_top.sv
module txtvga_top
    import txtvga_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int SCALE  = 2
) (
    input  logic       clk_pix,
    input  logic       rst_n,
    input  logic [2:0] fg_rgb,
    input  logic [2:0] bg_rgb,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       red,
    output logic       green,
    output logic       blue
);
    localparam int H_TOT   = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT   = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOT);
    localparam int VW      = $clog2(V_TOT);
    localparam int CELL_PX = GLYPH_PX * SCALE;
    localparam int COLS    = H_ACT / CELL_PX;
    localparam int ROWS    = V_ACT / CELL_PX;
    localparam int NCELLS  = COLS * ROWS;
    localparam int IW      = (NCELLS > 1) ? $clog2(NCELLS) : 1;

    typedef struct packed {
        logic       active;
        logic       hs;
        logic       vs;
        logic [2:0] line;
        logic [2:0] col;
    } s1_t;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        rgb_t rgb;
    } out_t;

    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;
    logic          active, in_hsync, in_vsync;
    logic [IW-1:0] idx_d;
    logic [6:0]    code;
    logic          pix;
    s1_t           s1_d, s1_q;
    out_t          o_d, o_q;

    txtvga_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk_pix  (clk_pix),
        .rst_n    (rst_n),
        .hpos     (hpos),
        .vpos     (vpos),
        .active   (active),
        .in_hsync (in_hsync),
        .in_vsync (in_vsync)
    );

    txtvga_charbuf #(
        .NCELLS(NCELLS), .IW(IW)
    ) u_charbuf (
        .clk_pix  (clk_pix),
        .rst_n    (rst_n),
        .cell_idx (idx_d),
        .code     (code)
    );

    txtvga_font u_font (
        .code (code),
        .line (s1_q.line),
        .col  (s1_q.col),
        .pix  (pix)
    );

    // Stage 1: cell address and in-cell offsets from the raster position.
    always_comb begin
        int hi;
        int vi;
        hi          = int'(hpos);
        vi          = int'(vpos);
        s1_d.active = active;
        s1_d.hs     = in_hsync;
        s1_d.vs     = in_vsync;
        s1_d.line   = 3'((vi % CELL_PX) / SCALE);
        s1_d.col    = 3'((hi % CELL_PX) / SCALE);
        idx_d       = active ? IW'((vi / CELL_PX) * COLS + (hi / CELL_PX)) : '0;
    end

    // Stage 2: glyph bit selects a colour; blanking forces black.
    always_comb begin
        o_d.hs_n = !s1_q.hs;
        o_d.vs_n = !s1_q.vs;
        if (s1_q.active) begin
            o_d.rgb = pix ? fg_rgb : bg_rgb;
        end else begin
            o_d.rgb = '0;
        end
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            o_q  <= '{hs_n: 1'b1, vs_n: 1'b1, rgb: 3'b000};
        end else begin
            s1_q <= s1_d;
            o_q  <= o_d;
        end
    end

    assign hsync_n = o_q.hs_n;
    assign vsync_n = o_q.vs_n;
    assign red     = o_q.rgb[2];
    assign green   = o_q.rgb[1];
    assign blue    = o_q.rgb[0];

endmodule

module txtvga_chk #(
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int H_TOT  = 800
) (
    input logic       clk_pix,
    input logic       rst_n,
    input logic [2:0] fg_rgb,
    input logic [2:0] bg_rgb,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       red,
    input logic       green,
    input logic       blue
);
    logic [2:0] rgb;
    logic       prev_hs_q, prev_vs_q, seen_q, hfall;
    int         hrun_q, per_q, age_q;

    assign rgb   = {red, green, blue};
    assign hfall = prev_hs_q && !hsync_n;

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            prev_hs_q <= 1'b1;
            prev_vs_q <= 1'b1;
            seen_q    <= 1'b0;
            hrun_q    <= 0;
            per_q     <= 0;
            age_q     <= 0;
        end else begin
            prev_hs_q <= hsync_n;
            prev_vs_q <= vsync_n;
            seen_q    <= seen_q | hfall;
            hrun_q    <= hsync_n ? 0 : hrun_q + 1;
            per_q     <= hfall ? 1 : per_q + 1;
            age_q     <= (age_q < 3) ? age_q + 1 : age_q;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (age_q < 2) |-> (hsync_n && vsync_n && rgb == 3'b000)); // R1
    AST_HSYNC_WIDTH: assert property (@(posedge clk_pix) disable iff (!rst_n)
        $rose(hsync_n) |-> (hrun_q == H_SYNC)); // R2
    AST_LINE_PERIOD: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (hfall && seen_q) |-> (per_q == H_TOT)); // R2
    AST_VSYNC_AT_COL0: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (vsync_n != prev_vs_q) |-> (seen_q && per_q == H_SYNC + H_BP)); // R3
    AST_SYNC_BLACK: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> (rgb == 3'b000)); // R4
    AST_COLOR_SOURCE: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (rgb != 3'b000) |-> (rgb == $past(fg_rgb) || rgb == $past(bg_rgb))); // R8

endmodule

bind txtvga_top txtvga_chk #(
    .H_SYNC(H_SYNC),
    .H_BP  (H_BP),
    .H_TOT (H_ACT + H_FP + H_SYNC + H_BP)
) u_chk (
    .clk_pix (clk_pix),
    .rst_n   (rst_n),
    .fg_rgb  (fg_rgb),
    .bg_rgb  (bg_rgb),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .red     (red),
    .green   (green),
    .blue    (blue)
);

// File: tb/txtvga_top_tb.sv
module txtvga_top_tb;
    localparam int CLK_PERIOD = 40;
    localparam int HA = 64, HF = 4, HS = 8, HB = 4;
    localparam int VA = 48, VF = 2, VS = 2, VB = 4;
    localparam int SC = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int CELL = 8 * SC;
    localparam int NCOL = HA / CELL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fg = 3'b111;
    logic [2:0] bg = 3'b000;
    logic       hsync_n, vsync_n, red, green, blue;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    bit finished = 1'b0;

    txtvga_top #(
        .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .SCALE(SC)
    ) u_dut (
        .clk_pix (clk),
        .rst_n   (rst_n),
        .fg_rgb  (fg),
        .bg_rgb  (bg),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .red     (red),
        .green   (green),
        .blue    (blue)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at k=%0d actual=%0d expected=%0d", tag, k, act, exp);
        end
    endtask

    function automatic int glyph_byte(input int code, input int line);
        if (line == 0) return 0;
        return ((code * 2) ^ line) & 255;
    endfunction

    function automatic int rgb_now();
        return int'({red, green, blue});
    endfunction

    task automatic check_idle(input string why);
        chk({"R1 hsync_n ", why}, int'(hsync_n), 1);
        chk({"R1 vsync_n ", why}, int'(vsync_n), 1);
        chk({"R1 rgb ", why}, rgb_now(), 0);
    endtask

    // Reference: output in cycle k shows raster position k-2 (R9).
    task automatic check_cycle();
        int p, h, v, code, line, col, bits, exp_rgb;
        if (k < 2) begin
            check_idle("pipeline fill");
            return;
        end
        p = k - 2;
        h = p % HT;
        v = (p / HT) % VT;
        chk("R2 R9 hsync_n", int'(hsync_n), (h >= HA + HF && h < HA + HF + HS) ? 0 : 1);
        chk("R3 R9 vsync_n", int'(vsync_n), (v >= VA + VF && v < VA + VF + VS) ? 0 : 1);
        if (h < HA && v < VA) begin
            code    = 32 + (((v / CELL) * NCOL + (h / CELL)) % 95);
            line    = (v % CELL) / SC;
            col     = (h % CELL) / SC;
            bits    = glyph_byte(code, line);
            exp_rgb = ((bits >> (7 - col)) & 1) != 0 ? int'(fg) : int'(bg);
            chk("R5 R6 R7 R8 R9 rgb active", rgb_now(), exp_rgb);
        end else begin
            chk("R4 rgb blanking", rgb_now(), 0);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            k++;
            check_cycle();
        end
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        check_cycle();
    endtask

    initial begin
        // R1: idle while reset is held
        repeat (3) begin
            @(negedge clk);
            check_idle("in reset");
        end
        release_reset();
        // White on black over a full frame plus a bit
        run(HT * VT + HT);
        // Complementary colours: tells foreground from background (R8)
        fg = 3'b010;
        bg = 3'b101;
        run(HT * VT);
        // Colour change in the middle of an active line (R8)
        run(HT * 3 + 20);
        fg = 3'b100;
        run(7);
        bg = 3'b001;
        run(HT * VT);
        // Reset in the middle of a frame, then realignment (R1, R9)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_idle("async assert");
        repeat (2) begin
            @(negedge clk);
            check_idle("held again");
        end
        fg = 3'b111;
        bg = 3'b000;
        release_reset();
        run(HT * VT + 2 * HT);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule